// File: doc/BRIEF.md
# Elapsed-Seconds Counter with Rate Divider

This block keeps a 32-bit count of elapsed seconds. A slow reference, nominally 32.768 kHz, reaches it as a one-cycle enable tick inside a faster system clock. A binary divider counts these ticks, and every time the divider wraps, the seconds count moves up by one. A register interface can load the count one byte at a time and can read the live count from a 32-bit output to take its own snapshot.

Taps on the same divider feed a square-wave output whose rate is picked by a two-bit selector. A byte write to the count restarts only the upper, seconds-producing section of the divider. The lower bits keep running, so the faster output rates go on without a glitch while the slowest rate starts a fresh phase.

A stop control freezes the divider and the count. A sticky stop flag records that time was lost. The flag comes up at reset and whenever the stop control is active, and it stays up until software clears it.

Top module: `secs_counter_top`

## Requirements
- R1: While running, `count_o` increases by exactly one each time the divider wraps, which is once every 2^DIV_W reference ticks.
- R2: Bit k of `cnt_be_i` replaces byte k (bits 8k+7..8k) of the count with the matching byte of `cnt_data_i` at the next clock. Unselected bytes keep their value. In a cycle with any write, no increment takes place.
- R3: Any counter byte write clears divider bits DIV_W-1..3 and leaves bits 2..0 alone. The next increment therefore comes 2^DIV_W minus (ticks mod 8) ticks after the write.
- R4: The square-wave source depends on the rate code. Code 00 selects divider bit DIV_W-1 (the 1 Hz rate). Code 01 selects divider bit 2 (reference/8). Code 10 selects divider bit 1 (reference/4). Code 11 selects the reference tick itself. `sqw_o` is registered and follows its source one clock later.
- R5: With code 00, a counter write drives the 1 Hz output low. It next goes high 2^(DIV_W-1) minus (ticks mod 8) ticks after the write.
- R6: With codes 01 and 10, a counter write does not alter the output level or its phase.
- R7: `sqw_o` is held high when the mode bit is 1 (interrupt mode) or the stop bit is 1.
- R8: While the stop bit is 1, reference ticks have no effect on the divider or the count. Counter byte writes are still accepted.
- R9: `osf_o` is 1 after reset and in every cycle that follows a cycle with the stop bit set. It stays 1 until `osf_clr_i` is pulsed while the stop bit is 0. A clear while stopped has no effect.
- R10: Reset gives count 0, divider 0, rate code 11, mode bit 0 and stop bit 0.
- R11: An increment from 32'hFFFFFFFF gives 32'h00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_tick_i | input | 1 | One-cycle reference tick enable |
| cnt_be_i | input | 4 | Per-byte write enables for the count |
| cnt_data_i | input | 32 | Count write data |
| ctrl_wr_i | input | 1 | Loads the control bits |
| ctrl_stop_i | input | 1 | Stop bit to load (1 halts timekeeping) |
| ctrl_mode_i | input | 1 | Mode bit to load (0 square wave, 1 interrupt mode) |
| ctrl_rate_i | input | 2 | Rate code to load |
| osf_clr_i | input | 1 | Clears the stop flag |
| osf_o | output | 1 | Sticky stop flag |
| count_o | output | 32 | Live seconds count |
| sqw_o | output | 1 | Square-wave output, high when released |

## Verification
The bench builds the block with DIV_W = 5, so one "second" lasts 32 ticks and the 1 Hz tap is divider bit 4. With this setting, many second boundaries fit into a short run. These include the shortened first second after a write, the restart of the 1 Hz phase, and the wrap of a count preloaded to all ones. The fast taps, bits 2 and 1, keep the same positions as at the default width. The checks on undisturbed fast rates therefore apply to the default build without change.

// File: rtl/secs_pkg.sv
package secs_pkg;

    localparam int FAST_W = 3;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_DIV8 = 2'b01,
        RATE_DIV4 = 2'b10,
        RATE_REF  = 2'b11
    } rate_e;

    typedef struct packed {
        logic  stop;
        logic  irq_mode;
        rate_e rate;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{stop: 1'b0, irq_mode: 1'b0, rate: RATE_REF};

    function automatic logic pick_tap(rate_e r, logic slow, logic d8, logic d4, logic ref_t);
        case (r)
            RATE_SLOW: return slow;
            RATE_DIV8: return d8;
            RATE_DIV4: return d4;
            default:   return ref_t;
        endcase
    endfunction

endpackage

// File: rtl/secs_divider.sv
module secs_divider
    import secs_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic tick_i,
    input  logic restart_i,
    output logic sec_pulse_o,
    output logic tap_slow_o,
    output logic tap_d8_o,
    output logic tap_d4_o
);
    localparam int SLOW_W = DIV_W - FAST_W;

    logic [DIV_W-1:0] div_q, div_step, div_d;

    always_comb begin
        div_step = (run_i && tick_i) ? div_q + DIV_W'(1) : div_q;
        div_d    = div_step;
        if (restart_i) begin
            div_d = {{SLOW_W{1'b0}}, div_step[FAST_W-1:0]};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign sec_pulse_o = run_i && tick_i && (&div_q);
    assign tap_slow_o  = div_q[DIV_W-1];
    assign tap_d8_o    = div_q[2];
    assign tap_d4_o    = div_q[1];

endmodule

// File: rtl/secs_count.sv
module secs_count #(
    parameter int CNT_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               sec_pulse_i,
    input  logic [CNT_W/8-1:0] be_i,
    input  logic [CNT_W-1:0]   data_i,
    output logic [CNT_W-1:0]   count_o
);
    localparam int NBYTES = CNT_W / 8;

    logic [CNT_W-1:0] count_q, base, count_d;

    always_comb begin
        if (|be_i) begin
            base = count_q;
        end else if (sec_pulse_i) begin
            base = count_q + CNT_W'(1);
        end else begin
            base = count_q;
        end
    end

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign count_d[8*k +: 8] = be_i[k] ? data_i[8*k +: 8] : base[8*k +: 8];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/secs_sqw.sv
module secs_sqw
    import secs_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  ctrl_t ctrl_i,
    input  logic  tap_slow_i,
    input  logic  tap_d8_i,
    input  logic  tap_d4_i,
    input  logic  tick_i,
    output logic  sqw_o
);
    logic sqw_q, sqw_d;

    always_comb begin
        if (ctrl_i.stop || ctrl_i.irq_mode) begin
            sqw_d = 1'b1;
        end else begin
            sqw_d = pick_tap(ctrl_i.rate, tap_slow_i, tap_d8_i, tap_d4_i, tick_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sqw_q <= 1'b1;
        end else begin
            sqw_q <= sqw_d;
        end
    end

    assign sqw_o = sqw_q;

endmodule

// File: rtl/secs_counter_top.sv
module secs_counter_top
    import secs_pkg::*;
#(
    parameter int DIV_W = 15,
    parameter int CNT_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               ref_tick_i,
    input  logic [CNT_W/8-1:0] cnt_be_i,
    input  logic [CNT_W-1:0]   cnt_data_i,
    input  logic               ctrl_wr_i,
    input  logic               ctrl_stop_i,
    input  logic               ctrl_mode_i,
    input  logic [1:0]         ctrl_rate_i,
    input  logic               osf_clr_i,
    output logic               osf_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               sqw_o
);
    ctrl_t ctrl_q;
    logic  osf_q;
    logic  sec_pulse, tap_slow, tap_d8, tap_d4;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= CTRL_RST;
        end else if (ctrl_wr_i) begin
            ctrl_q <= '{stop: ctrl_stop_i, irq_mode: ctrl_mode_i, rate: rate_e'(ctrl_rate_i)};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            osf_q <= 1'b1;
        end else if (ctrl_q.stop) begin
            osf_q <= 1'b1;
        end else if (osf_clr_i) begin
            osf_q <= 1'b0;
        end
    end

    assign osf_o = osf_q;

    secs_divider #(.DIV_W(DIV_W)) u_div (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .run_i      (!ctrl_q.stop),
        .tick_i     (ref_tick_i),
        .restart_i  (|cnt_be_i),
        .sec_pulse_o(sec_pulse),
        .tap_slow_o (tap_slow),
        .tap_d8_o   (tap_d8),
        .tap_d4_o   (tap_d4)
    );

    secs_count #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sec_pulse_i(sec_pulse),
        .be_i       (cnt_be_i),
        .data_i     (cnt_data_i),
        .count_o    (count_o)
    );

    secs_sqw u_sqw (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ctrl_i    (ctrl_q),
        .tap_slow_i(tap_slow),
        .tap_d8_i  (tap_d8),
        .tap_d4_i  (tap_d4),
        .tick_i    (ref_tick_i),
        .sqw_o     (sqw_o)
    );

endmodule

// File: rtl/secs_counter_chk.sv
module secs_counter_chk #(
    parameter int CNT_W = 32
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [CNT_W/8-1:0] cnt_be_i,
    input logic               osf_clr_i,
    input logic               osf_o,
    input logic [CNT_W-1:0]   count_o,
    input logic               sqw_o,
    input logic               stop_q,
    input logic               mode_q
);
    // R1 / R11: without a write the count holds or steps by one (wrapping)
    p_count_step_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !(|cnt_be_i) |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + CNT_W'(1)));

    // R8: stopped and no write keeps the count
    p_stop_holds_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (stop_q && !(|cnt_be_i)) |=> $stable(count_o));

    // R7: released output level
    p_sqw_released_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (stop_q || mode_q) |=> sqw_o);

    // R9: stopped forces the flag
    p_osf_on_stop_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        stop_q |=> osf_o);

    // R9: flag is sticky without a clear
    p_osf_sticky_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (osf_o && !osf_clr_i) |=> osf_o);

endmodule

bind secs_counter_top secs_counter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cnt_be_i (cnt_be_i),
    .osf_clr_i(osf_clr_i),
    .osf_o    (osf_o),
    .count_o  (count_o),
    .sqw_o    (sqw_o),
    .stop_q   (ctrl_q.stop),
    .mode_q   (ctrl_q.irq_mode)
);

// File: tb/secs_counter_top_tb_top.sv
module secs_counter_top_tb_top;
    localparam int DIV_W = 5;
    localparam int PER   = 1 << DIV_W;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        ref_tick_i = 1'b0;
    logic [3:0]  cnt_be_i = '0;
    logic [31:0] cnt_data_i = '0;
    logic        ctrl_wr_i = 1'b0;
    logic        ctrl_stop_i = 1'b0;
    logic        ctrl_mode_i = 1'b0;
    logic [1:0]  ctrl_rate_i = 2'b11;
    logic        osf_clr_i = 1'b0;
    logic        osf_o;
    logic [31:0] count_o;
    logic        sqw_o;

    int n_checks = 0;
    int n_fail   = 0;
    int mdiv     = 0;
    logic [31:0] mcnt = '0;
    logic        mstop = 1'b0;
    bit          done = 1'b0;

    always #4 clk_i = ~clk_i;

    secs_counter_top #(.DIV_W(DIV_W)) dut_i (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i) ref_tick_i = 1'b1;
            @(negedge clk_i) ref_tick_i = 1'b0;
            if (!mstop) begin
                if (mdiv == PER - 1) mcnt = mcnt + 1;
                mdiv = (mdiv + 1) % PER;
            end
        end
        @(negedge clk_i);
    endtask

    task automatic wr_count(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk_i) begin cnt_be_i = be; cnt_data_i = d; end
        @(negedge clk_i) cnt_be_i = '0;
        for (int k = 0; k < 4; k++) if (be[k]) mcnt[8*k +: 8] = d[8*k +: 8];
        mdiv = mdiv % 8;
        @(negedge clk_i);
    endtask

    task automatic wr_ctrl(input logic stop, input logic mode, input logic [1:0] rate);
        @(negedge clk_i) begin ctrl_wr_i = 1'b1; ctrl_stop_i = stop; ctrl_mode_i = mode; ctrl_rate_i = rate; end
        @(negedge clk_i) ctrl_wr_i = 1'b0;
        mstop = stop;
        @(negedge clk_i);
    endtask

    task automatic t_reset();
        @(negedge clk_i);
        check(count_o == 32'h0, "R10 count after reset", count_o, 32'h0);
        check(osf_o == 1'b1, "R9 flag after reset", 32'(osf_o), 32'h1);
        check(sqw_o == 1'b0, "R10 default rate 11 idle", 32'(sqw_o), 32'h0);
        @(negedge clk_i) ref_tick_i = 1'b1;
        @(negedge clk_i) ref_tick_i = 1'b0;
        check(sqw_o == 1'b1, "R4 rate 11 follows tick", 32'(sqw_o), 32'h1);
        mdiv = 1;
        @(negedge clk_i);
        check(sqw_o == 1'b0, "R4 rate 11 tick gone", 32'(sqw_o), 32'h0);
        @(negedge clk_i) osf_clr_i = 1'b1;
        @(negedge clk_i) osf_clr_i = 1'b0;
        check(osf_o == 1'b0, "R9 flag cleared", 32'(osf_o), 32'h0);
    endtask

    task automatic t_count();
        ticks(PER - 1);
        check(count_o == mcnt && mcnt == 32'd1, "R1 one second", count_o, 32'd1);
        ticks(PER);
        check(count_o == 32'd2, "R1 two seconds", count_o, 32'd2);
        ticks(5);
        check(count_o == 32'd2, "R1 partial", count_o, 32'd2);
    endtask

    task automatic t_byte();
        int f;
        wr_count(4'b0100, 32'h11AB2233);
        check(count_o == 32'h00AB0002, "R2 byte 2 write", count_o, 32'h00AB0002);
        f = mdiv;
        ticks(PER - f - 1);
        check(count_o == 32'h00AB0002, "R3 before shortened second", count_o, 32'h00AB0002);
        ticks(1);
        check(count_o == 32'h00AB0003, "R3 shortened second", count_o, 32'h00AB0003);
    endtask

    task automatic t_slow_phase();
        wr_ctrl(1'b0, 1'b0, 2'b00);
        ticks(3);
        wr_count(4'b0001, 32'h00000055);
        check(count_o == 32'h00AB0055, "R2 byte 0 write", count_o, 32'h00AB0055);
        check(sqw_o == 1'b0, "R5 low after write", 32'(sqw_o), 32'h0);
        ticks(PER/2 - mdiv - 1);
        check(sqw_o == 1'b0, "R5 still low", 32'(sqw_o), 32'h0);
        ticks(1);
        check(sqw_o == 1'b1, "R5 rises on new phase", 32'(sqw_o), 32'h1);
        wr_count(4'b0010, 32'h00007700);
        check(sqw_o == 1'b0, "R5 restart drives low", 32'(sqw_o), 32'h0);
    endtask

    task automatic t_fast();
        logic exp_b;
        wr_ctrl(1'b0, 1'b0, 2'b01);
        while (mdiv % 8 != 5) ticks(1);
        exp_b = 1'((mdiv >> 2) & 1);
        check(sqw_o == exp_b, "R4 rate 01 tap", 32'(sqw_o), 32'(exp_b));
        wr_count(4'b1000, 32'h3C000000);
        check(sqw_o == exp_b, "R6 rate 01 undisturbed", 32'(sqw_o), 32'(exp_b));
        wr_ctrl(1'b0, 1'b0, 2'b10);
        exp_b = 1'((mdiv >> 1) & 1);
        check(sqw_o == exp_b, "R4 rate 10 tap", 32'(sqw_o), 32'(exp_b));
        wr_count(4'b0001, 32'h00000001);
        check(sqw_o == exp_b, "R6 rate 10 undisturbed", 32'(sqw_o), 32'(exp_b));
        ticks(1);
        exp_b = 1'((mdiv >> 1) & 1);
        check(sqw_o == exp_b, "R6 rate 10 continues", 32'(sqw_o), 32'(exp_b));
    endtask

    task automatic t_release();
        wr_ctrl(1'b0, 1'b1, 2'b10);
        ticks(2);
        check(sqw_o == 1'b1, "R7 mode 1 released", 32'(sqw_o), 32'h1);
        wr_ctrl(1'b1, 1'b0, 2'b11);
        @(negedge clk_i) ref_tick_i = 1'b0;
        check(sqw_o == 1'b1, "R7 stop released", 32'(sqw_o), 32'h1);
    endtask

    task automatic t_stop();
        logic [31:0] held;
        held = count_o;
        ticks(PER + 3);
        check(count_o == held, "R8 stopped count", count_o, held);
        check(osf_o == 1'b1, "R9 flag while stopped", 32'(osf_o), 32'h1);
        @(negedge clk_i) osf_clr_i = 1'b1;
        @(negedge clk_i) osf_clr_i = 1'b0;
        check(osf_o == 1'b1, "R9 clear ignored stopped", 32'(osf_o), 32'h1);
        wr_count(4'b0001, 32'h00000009);
        check(count_o == mcnt, "R8 write while stopped", count_o, mcnt);
        wr_ctrl(1'b0, 1'b0, 2'b11);
        @(negedge clk_i) osf_clr_i = 1'b1;
        @(negedge clk_i) osf_clr_i = 1'b0;
        check(osf_o == 1'b0, "R9 clear after restart", 32'(osf_o), 32'h0);
        ticks(PER - mdiv);
        check(count_o == mcnt, "R1 runs after restart", count_o, mcnt);
    endtask

    task automatic t_wrap();
        wr_count(4'b1111, 32'hFFFFFFFF);
        ticks(PER - mdiv - 1);
        check(count_o == 32'hFFFFFFFF, "R11 before wrap", count_o, 32'hFFFFFFFF);
        ticks(1);
        check(count_o == 32'h0, "R11 wrap to zero", count_o, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_i = 1'b0;
        t_reset();
        t_count();
        t_byte();
        t_slow_phase();
        t_fast();
        t_release();
        t_stop();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule